// File: doc/BRIEF.md
# Virtually indexed, physically tagged L1 data lookup

This block is the lookup stage of a 4-way set-associative level-one data cache. It has 128 sets and 32-byte lines. The set index and the word position come from the low 12 bits of the address, which are the same before and after translation. The block can therefore start reading the tag and data arrays in the same cycle the virtual address arrives. The translated page number from the TLB comes one cycle later. It is checked against the four stored tags of the set that was read.

On a hit, the block returns the addressed 32-bit word. On a miss, it asks the next level for the whole line and takes eight words back in ascending order. It writes them into the way picked by a per-set pseudo-LRU tree and then answers with the requested word.

If translation is late, the compare stalls until a valid page number is presented. The set is then read again before the compare. A word access whose offset is not a multiple of four is answered at once with an error.

The block handles one request at a time. It shows when it can take a new one.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset, `ready_o` is 1, `rsp_valid_o` and `fill_req_o` are 0, and every line is invalid, so the first access to any set misses.
- R2: The set index is `req_off_i[11:5]` and the word within the line is `req_off_i[4:2]`. The tag compared is the whole 20-bit `ppn_i`, so lines with the same offset but a different page number, or with the same page number but a different index, are distinct.
- R3: When the page number is presented in the cycle after the request is accepted and the line is present, `rsp_valid_o` is 1 for one cycle, one clock after that presentation. `rsp_err_o` is 0 and `rsp_data_o` is the stored word.
- R4: On a miss, `fill_req_o` is raised with `fill_line_o = {ppn, index}`. The line is held stable until the eighth `fill_valid_i` beat. The beats carry words 0 to 7 in order. One clock after the last beat, the requested word is returned, and later accesses to that line hit.
- R5: If `ppn_valid_i` is 0 when the compare is due, there is no response and no fill request until it is 1. The set is read again and the response follows two clocks after the page number is presented.
- R6: A request with `req_off_i[1:0]` not equal to 0 gets `rsp_valid_o` and `rsp_err_o` one clock later, with `rsp_data_o` equal to 0. It makes no fill request and changes no cache state.
- R7: Each set keeps a 3-bit tree. Bit 0 set means the victim is in ways 2-3, otherwise it is in ways 0-1. Bit 1 picks way 1 over way 0, and bit 2 picks way 3 over way 2. A hit or a fill on a way turns the bits on its path away from that way.
- R8: While a request is in progress, `ready_o` is 0 and `req_i` is ignored. Exactly one response is given per accepted request.
- R9: Fill beats may have idle cycles between them. `fill_valid_i` outside a fill changes no stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Read request, taken when `ready_o` is 1 |
| req_off_i | input | 12 | Page-offset bits of the virtual address |
| ready_o | output | 1 | Block is idle and takes a request |
| ppn_valid_i | input | 1 | Page number from translation is valid |
| ppn_i | input | 20 | Physical page number (tag) |
| rsp_valid_o | output | 1 | Response valid, one cycle |
| rsp_err_o | output | 1 | Misaligned access |
| rsp_data_o | output | 32 | Returned word |
| fill_req_o | output | 1 | Line fill request to the next level |
| fill_line_o | output | 27 | Line address of the fill: tag then index |
| fill_valid_i | input | 1 | Fill beat valid |
| fill_data_i | input | 32 | Fill beat word |

## Verification
The hardest state to reach is eviction order within one set: it only shows when all four ways of a set hold different page numbers and a fifth one arrives. The bench fills one set with four tags and re-touches them in a chosen order. It then brings in new tags and checks which earlier tags have turned into misses against a behavioural tree model. Late translation, gapped fill beats, requests poked in mid-fill and stray fill beats while idle are each driven into that same traffic.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int WAYS  = 4;
  localparam int WAY_W = 2;
  localparam int TREE_W = WAYS - 1;
  typedef enum logic [1:0] {ST_IDLE, ST_CMP, ST_STALL, ST_FILL} state_e;

  function automatic logic [WAY_W-1:0] tree_victim(input logic [TREE_W-1:0] t);
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction
endpackage

// File: rtl/vipt_plru.sv
module vipt_plru import vipt_pkg::*; #(
  parameter int SETS = 128,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  output logic [WAY_W-1:0] victim_o,
  input  logic             touch_i,
  input  logic [IDX_W-1:0] touch_idx_i,
  input  logic [WAY_W-1:0] touch_way_i
);
  logic [SETS-1:0][TREE_W-1:0] tree_q;
  logic [TREE_W-1:0] tree_nxt;

  assign victim_o = tree_victim(tree_q[idx_i]);

  always_comb begin
    tree_nxt = tree_q[touch_idx_i];
    if (!touch_way_i[1]) begin
      tree_nxt[0] = 1'b1;
      tree_nxt[1] = ~touch_way_i[0];
    end else begin
      tree_nxt[0] = 1'b0;
      tree_nxt[2] = ~touch_way_i[0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tree_q <= '0;
    else if (touch_i) tree_q[touch_idx_i] <= tree_nxt;
  end

  // R7: a touched way is never the next victim of its set
  a_r7_touch_redirects: assert property (@(posedge clk_i) disable iff (!rst_ni)
    touch_i |=> tree_victim(tree_q[$past(touch_idx_i)]) != $past(touch_way_i));
endmodule

// File: rtl/vipt_way.sv
module vipt_way #(
  parameter int TAG_W  = 20,
  parameter int SETS   = 128,
  parameter int WORDS  = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(SETS),
  localparam int WRD_W = $clog2(WORDS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [WRD_W-1:0]  rd_word_i,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic              rd_vld_o,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_data_en_i,
  input  logic [WRD_W-1:0]  wr_word_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wr_tag_en_i,
  input  logic [TAG_W-1:0]  wr_tag_i
);
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [DATA_W-1:0] data_mem [SETS*WORDS];
  logic [SETS-1:0]   vld_q;

  always_ff @(posedge clk_i) begin
    if (wr_tag_en_i)  tag_mem[wr_idx_i] <= wr_tag_i;
    if (wr_data_en_i) data_mem[{wr_idx_i, wr_word_i}] <= wr_data_i;
    if (rd_en_i) begin
      rd_tag_o  <= tag_mem[rd_idx_i];
      rd_data_o <= data_mem[{rd_idx_i, rd_word_i}];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q    <= '0;
      rd_vld_o <= 1'b0;
    end else begin
      if (wr_tag_en_i) vld_q[wr_idx_i] <= 1'b1;
      if (rd_en_i) rd_vld_o <= vld_q[rd_idx_i];
    end
  end
endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup import vipt_pkg::*; #(
  parameter int TAG_W  = 20,
  parameter int SETS   = 128,
  parameter int LINE_B = 32,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(SETS),
  localparam int OFF_W  = $clog2(LINE_B),
  localparam int WB_W   = $clog2(DATA_W/8),
  localparam int WORDS  = LINE_B / (DATA_W/8),
  localparam int WRD_W  = $clog2(WORDS),
  localparam int PAGE_W = IDX_W + OFF_W
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   req_i,
  input  logic [PAGE_W-1:0]      req_off_i,
  output logic                   ready_o,
  input  logic                   ppn_valid_i,
  input  logic [TAG_W-1:0]       ppn_i,
  output logic                   rsp_valid_o,
  output logic                   rsp_err_o,
  output logic [DATA_W-1:0]      rsp_data_o,
  output logic                   fill_req_o,
  output logic [TAG_W+IDX_W-1:0] fill_line_o,
  input  logic                   fill_valid_i,
  input  logic [DATA_W-1:0]      fill_data_i
);
  state_e state_q;
  logic [PAGE_W-1:WB_W] off_q;
  logic [TAG_W-1:0]  ppn_q;
  logic              use_q;
  logic [WAY_W-1:0]  victim_q;
  logic [WRD_W-1:0]  beat_q;
  logic [DATA_W-1:0] cap_q;

  logic [IDX_W-1:0] idx_q, rd_idx;
  logic [WRD_W-1:0] word_q, rd_word;
  logic misalign, rd_en, cmp_go, hit, beat_last;
  logic [TAG_W-1:0] cmp_tag;
  logic [WAYS-1:0] hit_vec;
  logic [WAY_W-1:0] hit_way, plru_victim;
  logic [DATA_W-1:0] hit_data;
  logic [TAG_W-1:0]  rd_tag  [WAYS];
  logic [DATA_W-1:0] rd_data [WAYS];
  logic [WAYS-1:0]   rd_vld;

  assign idx_q    = off_q[PAGE_W-1:OFF_W];
  assign word_q   = off_q[OFF_W-1:WB_W];
  assign misalign = |req_off_i[WB_W-1:0];
  assign rd_en    = (state_q == ST_IDLE && req_i && !misalign) ||
                    (state_q == ST_STALL && ppn_valid_i);
  assign rd_idx   = (state_q == ST_IDLE) ? req_off_i[PAGE_W-1:OFF_W] : idx_q;
  assign rd_word  = (state_q == ST_IDLE) ? req_off_i[OFF_W-1:WB_W] : word_q;
  assign cmp_go   = state_q == ST_CMP && (use_q || ppn_valid_i);
  assign cmp_tag  = use_q ? ppn_q : ppn_i;
  assign beat_last = state_q == ST_FILL && fill_valid_i && beat_q == WRD_W'(WORDS-1);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit_vec[w] = rd_vld[w] && rd_tag[w] == cmp_tag;
    vipt_way #(.TAG_W(TAG_W), .SETS(SETS), .WORDS(WORDS), .DATA_W(DATA_W)) u_way (
      .clk_i, .rst_ni,
      .rd_en_i(rd_en), .rd_idx_i(rd_idx), .rd_word_i(rd_word),
      .rd_tag_o(rd_tag[w]), .rd_vld_o(rd_vld[w]), .rd_data_o(rd_data[w]),
      .wr_idx_i(idx_q),
      .wr_data_en_i(state_q == ST_FILL && fill_valid_i && victim_q == WAY_W'(w)),
      .wr_word_i(beat_q), .wr_data_i(fill_data_i),
      .wr_tag_en_i(beat_last && victim_q == WAY_W'(w)), .wr_tag_i(ppn_q)
    );
  end

  always_comb begin
    hit_way  = '0;
    hit_data = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) begin
        hit_way  = WAY_W'(w);
        hit_data = hit_data | rd_data[w];
      end
    end
  end
  assign hit = |hit_vec;

  vipt_plru #(.SETS(SETS)) u_plru (
    .clk_i, .rst_ni,
    .idx_i(idx_q), .victim_o(plru_victim),
    .touch_i((cmp_go && hit) || beat_last), .touch_idx_i(idx_q),
    .touch_way_i(beat_last ? victim_q : hit_way)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      off_q       <= '0;
      ppn_q       <= '0;
      use_q       <= 1'b0;
      victim_q    <= '0;
      beat_q      <= '0;
      cap_q       <= '0;
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          if (misalign) begin
            rsp_valid_o <= 1'b1;
            rsp_err_o   <= 1'b1;
            rsp_data_o  <= '0;
          end else begin
            off_q   <= req_off_i[PAGE_W-1:WB_W];
            use_q   <= 1'b0;
            state_q <= ST_CMP;
          end
        end
        ST_CMP: begin
          if (!cmp_go) begin
            state_q <= ST_STALL;
          end else if (hit) begin
            rsp_valid_o <= 1'b1;
            rsp_data_o  <= hit_data;
            state_q     <= ST_IDLE;
          end else begin
            ppn_q    <= cmp_tag;
            victim_q <= plru_victim;
            beat_q   <= '0;
            state_q  <= ST_FILL;
          end
        end
        ST_STALL: if (ppn_valid_i) begin
          // translation arrived late: set is re-read, compare uses held ppn
          ppn_q   <= ppn_i;
          use_q   <= 1'b1;
          state_q <= ST_CMP;
        end
        ST_FILL: if (fill_valid_i) begin
          beat_q <= beat_q + 1'b1;
          if (beat_q == word_q) cap_q <= fill_data_i;
          if (beat_last) begin
            rsp_valid_o <= 1'b1;
            rsp_data_o  <= (beat_q == word_q) ? fill_data_i : cap_q;
            state_q     <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o     = state_q == ST_IDLE;
  assign fill_req_o  = state_q == ST_FILL;
  assign fill_line_o = {ppn_q, idx_q};

  a_r6_err_with_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> rsp_valid_o);
  a_r6_misalign_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_i && misalign) |=> (rsp_valid_o && rsp_err_o && !fill_req_o));
  a_r4_line_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_req_o && $past(fill_req_o)) |-> $stable(fill_line_o));
  a_r5_stall_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMP && !use_q && !ppn_valid_i) |=> (!rsp_valid_o && !fill_req_o));
  a_r3_single_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMP) |-> $onehot0(hit_vec));
  a_r8_rsp_ends_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_err_o) |-> $past(!ready_o));
endmodule

// File: tb/vipt_l1_lookup_test.sv
`timescale 1ns/1ps
module vipt_l1_lookup_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 1'b0;
  logic [11:0] req_off_i = '0;
  logic ready_o;
  logic ppn_valid_i = 1'b0;
  logic [19:0] ppn_i = '0;
  logic rsp_valid_o, rsp_err_o, fill_req_o;
  logic [31:0] rsp_data_o;
  logic [26:0] fill_line_o;
  logic fill_valid_i = 1'b0;
  logic [31:0] fill_data_i = '0;

  always #2.5 clk = ~clk;

  vipt_l1_lookup uut (
    .clk_i(clk), .rst_ni, .req_i, .req_off_i, .ready_o, .ppn_valid_i, .ppn_i,
    .rsp_valid_o, .rsp_err_o, .rsp_data_o, .fill_req_o, .fill_line_o,
    .fill_valid_i, .fill_data_i
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // behavioural model of cache contents and per-set tree
  logic [19:0] m_tag [128][4];
  bit          m_vld [128][4];
  bit [2:0]    m_tree [128];

  function automatic logic [31:0] mem_word(input logic [19:0] t, input int idx, input int w);
    return {t, idx[6:0], w[2:0], 2'b00} ^ 32'h5a5a_c3c3;
  endfunction

  function automatic int m_victim(input int idx);
    if (m_tree[idx][0]) return m_tree[idx][2] ? 3 : 2;
    return m_tree[idx][1] ? 1 : 0;
  endfunction

  task automatic m_touch(input int idx, input int w);
    if (w < 2) begin m_tree[idx][0] = 1'b1; m_tree[idx][1] = (w == 0); end
    else begin m_tree[idx][0] = 1'b0; m_tree[idx][2] = (w == 2); end
  endtask

  task automatic access(input logic [11:0] off, input logic [19:0] tag,
                        input int stall, input int gap, input bit poke, input string rq);
    int idx = int'(off[11:5]);
    int w = int'(off[4:2]);
    int hw = -1;
    for (int k = 0; k < 4; k++) if (m_vld[idx][k] && m_tag[idx][k] == tag) hw = k;
    @(negedge clk); req_i = 1'b1; req_off_i = off;
    @(negedge clk); req_i = 1'b0;
    if (off[1:0] != 2'b00) begin
      chk(rsp_valid_o && rsp_err_o, {rq, " R6 err response"}, {rsp_valid_o, rsp_err_o}, 2'b11);
      chk(rsp_data_o == 0 && !fill_req_o && ready_o, {rq, " R6 no fill, data zero"}, rsp_data_o, 0);
      return;
    end
    chk(!ready_o, {rq, " R8 busy after accept"}, ready_o, 0);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(!rsp_valid_o && !fill_req_o, {rq, " R5 quiet during stall"}, {rsp_valid_o, fill_req_o}, 0);
    end
    ppn_valid_i = 1'b1; ppn_i = tag;
    @(negedge clk); ppn_valid_i = 1'b0; ppn_i = '0;
    if (stall > 0) begin
      chk(!rsp_valid_o, {rq, " R5 reread cycle"}, rsp_valid_o, 0);
      @(negedge clk);
    end
    if (hw >= 0) begin
      chk(rsp_valid_o && !rsp_err_o && rsp_data_o == mem_word(tag, idx, w),
          {rq, " R3 hit data"}, rsp_data_o, mem_word(tag, idx, w));
      m_touch(idx, hw);
    end else begin
      int v = m_victim(idx);
      chk(fill_req_o && fill_line_o == {tag, off[11:5]}, {rq, " R4 fill request"},
          {4'b0, fill_req_o, fill_line_o}, {5'b1, tag, off[11:5]});
      for (int b = 0; b < 8; b++) begin
        fill_valid_i = 1'b1; fill_data_i = mem_word(tag, idx, b);
        if (poke && b == 3) begin req_i = 1'b1; req_off_i = off ^ 12'h024; end
        @(negedge clk);
        fill_valid_i = 1'b0; fill_data_i = '0; req_i = 1'b0;
        if (b < 7) begin
          chk(!rsp_valid_o && fill_req_o, {rq, " R4 no early response"}, rsp_valid_o, 0);
          for (int g = 0; g < gap; g++) begin
            fill_valid_i = 1'b0;
            @(negedge clk);
          end
        end
      end
      chk(rsp_valid_o && !rsp_err_o && rsp_data_o == mem_word(tag, idx, w),
          {rq, " R4 fill response"}, rsp_data_o, mem_word(tag, idx, w));
      m_tag[idx][v] = tag; m_vld[idx][v] = 1'b1;
      m_touch(idx, v);
    end
    @(negedge clk);
    chk(!rsp_valid_o && ready_o && !fill_req_o, {rq, " R8 single response"},
        {rsp_valid_o, ready_o, fill_req_o}, 3'b010);
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) begin
      m_tree[i] = '0;
      for (int k = 0; k < 4; k++) begin m_vld[i][k] = 1'b0; m_tag[i][k] = '0; end
    end
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(ready_o && !rsp_valid_o && !fill_req_o, "R1 reset outputs",
        {ready_o, rsp_valid_o, fill_req_o}, 3'b100);

    access(12'h044, 20'h12345, 0, 0, 0, "R1 first miss");
    access(12'h044, 20'h12345, 0, 0, 0, "R3 hit");
    access(12'h05c, 20'h12345, 0, 0, 0, "R2 other word");
    access(12'h064, 20'h12345, 0, 0, 0, "R2 other index miss");
    access(12'h044, 20'h92345, 0, 0, 0, "R2 tag msb miss");
    access(12'h048, 20'h12345, 3, 0, 0, "R5 stalled hit");
    access(12'h0a8, 20'h00777, 2, 0, 0, "R5 stalled miss");
    access(12'h046, 20'h12345, 0, 0, 0, "R6 misaligned");
    access(12'h045, 20'h00000, 0, 0, 0, "R6 misaligned odd");
    access(12'h040, 20'h12345, 0, 0, 0, "R6 state kept");

    // R7: fill one set with four tags, reorder, then evict
    for (int t = 0; t < 4; t++) access(12'h0bc, 20'hb0000 + t, 0, 0, 0, "R7 fill set");
    for (int t = 0; t < 4; t++) access(12'h0a0, 20'hb0000 + t, 0, 0, 0, "R7 all present");
    access(12'h0a4, 20'hb0002, 0, 0, 0, "R7 touch");
    access(12'h0a4, 20'hb0000, 0, 0, 0, "R7 touch");
    access(12'h0b0, 20'hb0010, 0, 0, 0, "R7 evict one");
    for (int t = 0; t < 4; t++) access(12'h0b4, 20'hb0000 + t, 0, 0, 0, "R7 survivor check");
    access(12'h0a0, 20'hb0011, 0, 0, 0, "R7 evict two");
    access(12'h0a0, 20'hb0010, 0, 0, 0, "R7 newer kept");

    access(12'h3e0, 20'h0abcd, 0, 2, 0, "R9 gapped fill");
    access(12'h3fc, 20'h0abcd, 0, 0, 0, "R9 gapped data");
    @(negedge clk); fill_valid_i = 1'b1; fill_data_i = 32'hdead_beef;
    @(negedge clk); fill_valid_i = 1'b0; fill_data_i = '0;
    chk(!rsp_valid_o && ready_o, "R9 stray beat no response", rsp_valid_o, 0);
    access(12'h3e0, 20'h0abcd, 0, 0, 0, "R9 stray beat ignored");
    access(12'h044, 20'h12345, 0, 0, 0, "R9 stray beat other line");

    access(12'h51c, 20'h55555, 0, 1, 1, "R8 poke during fill");
    access(12'h538, 20'h55555, 0, 0, 0, "R8 poked offset not filled");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule